// File: doc/BRIEF.md
# Address-Stable Automatic Sleep Detector

This block sits on the read path of a memory array. It watches the address bus and counts the clock cycles during which the address has not changed. The count limit is the sum of two parameters: the normal access time and a fixed safety margin, both in clock cycles. When the count reaches that limit, the block raises a sleep flag. Surrounding logic can use the flag to power down the array's sense circuitry.

While the block is asleep, the data of the last completed read stays in an output register and remains valid on the outputs. Any change of address clears the sleep flag in the same cycle and restarts the count. The array then serves a normal access, and its data-valid pulse loads fresh data into the output register.

No chip-enable, write-enable or output-enable signal takes part in the sleep decision. Only the stability of the address matters.

Top module: `addr_idle_sleep`

## Requirements
- R1: With the address unchanged, `sleepFlag` rises exactly ACCESS_CYC+MARGIN_CYC rising clock edges after the edge at which the address last changed (9 edges with the default parameters), and not one edge earlier.
- R2: Once set, `sleepFlag` stays high for as long as the address stays unchanged.
- R3: An address that differs from the value seen at the previous clock edge drives `sleepFlag` low combinationally in that same cycle. The stability count restarts at zero from that edge, including when the count is part-way to its limit.
- R4: While `sleepFlag` is high, `dataOut` holds its value, and a `dataValid` pulse has no effect on it.
- R5: While `sleepFlag` is low, a `dataValid` pulse sampled at a rising edge loads `arrayData` into `dataOut`. The new value is visible right after that edge.
- R6: After reset, `sleepFlag` is 0, `dataOut` is all zeros, and the stability count is cleared, with the held address taken as all zeros. An all-zero address held through and after reset therefore sleeps after the full ACCESS_CYC+MARGIN_CYC edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| addrIn | input | ADDR_W | Read address bus |
| arrayData | input | DATA_W | Fresh data from the array |
| dataValid | input | 1 | One-cycle pulse marking completed array data |
| sleepFlag | output | 1 | High while the block is in automatic sleep |
| dataOut | output | DATA_W | Latched read data |

## Verification
On every cycle, the assertions check four things:
- the stability count never passes its limit;
- an address change deasserts the sleep state at the next edge;
- the output data never moves while the block is asleep, and never moves without a data-valid pulse;
- sleep only begins after a cycle with a stable address.

Only the bench's scenarios can show the following:
- the exact edge on which sleep begins;
- the count restarting after an address change part-way through;
- a data-valid pulse being ignored during sleep;
- the exact values loaded by several reads.

// File: rtl/addr_idle_sleep_pkg.sv
package addr_idle_sleep_pkg;

  // Strobes sent from the control to the datapath
  typedef struct packed {
    logic clrCount;   // restart the stability count
    logic incCount;   // advance the stability count
    logic loadData;   // capture array data into the output register
  } sleepStrobes_t;

endpackage

// File: rtl/addr_idle_sleep_dp.sv
module addr_idle_sleep_dp
  import addr_idle_sleep_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int THRESH = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] arrayData,
  input  sleepStrobes_t     strobes,
  output logic              addrChange,
  output logic              reachNext,
  output logic              countFull,
  output logic [DATA_W-1:0] dataOut
);

  localparam int CNT_W = $clog2(THRESH + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESH);
  localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(THRESH - 1);

  logic [ADDR_W-1:0] prevAddr;
  logic [CNT_W-1:0]  stableCount;
  logic [DATA_W-1:0] dataQ;

  assign addrChange = (addrIn != prevAddr);
  assign reachNext  = (stableCount >= LIMIT_M1);
  assign countFull  = (stableCount == LIMIT);
  assign dataOut    = dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAddr <= '0;
    end else begin
      prevAddr <= addrIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stableCount <= '0;
    end else if (strobes.clrCount) begin
      stableCount <= '0;
    end else if (strobes.incCount) begin
      stableCount <= stableCount + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
    end else if (strobes.loadData) begin
      dataQ <= arrayData;
    end
  end

  // R1/R2: the count saturates at its limit
  p_count_bounded_r1: assert property (@(posedge clk) disable iff (!rstN)
    stableCount <= LIMIT)
    else $error("stability count passed its limit");

  // R3: a change seen at an edge leaves the count at zero
  p_count_restart_r3: assert property (@(posedge clk) disable iff (!rstN)
    addrChange |=> (stableCount == '0))
    else $error("count did not restart after address change");

endmodule

// File: rtl/addr_idle_sleep_ctrl.sv
module addr_idle_sleep_ctrl
  import addr_idle_sleep_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          addrChange,
  input  logic          reachNext,
  input  logic          countFull,
  input  logic          dataValid,
  output sleepStrobes_t strobes,
  output logic          sleepFlag
);

  logic sleepQ;

  // The flag drops in the very cycle the address moves
  assign sleepFlag = sleepQ && !addrChange;

  always_comb begin
    strobes.clrCount = addrChange;
    strobes.incCount = !addrChange && !countFull;
    strobes.loadData = dataValid && !sleepFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepQ <= 1'b0;
    end else if (addrChange) begin
      sleepQ <= 1'b0;
    end else begin
      sleepQ <= reachNext;
    end
  end

  // R3: a moving address never leaves the block asleep at the next edge
  p_wake_on_change_r3: assert property (@(posedge clk) disable iff (!rstN)
    addrChange |=> !sleepQ)
    else $error("sleep state survived an address change");

  // R1: sleep can only begin after a cycle with a stable address
  p_sleep_after_stable_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepQ) |-> $past(!addrChange))
    else $error("sleep began right after an address change");

endmodule

// File: rtl/addr_idle_sleep.sv
module addr_idle_sleep
  import addr_idle_sleep_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int ACCESS_CYC = 6,
  parameter int MARGIN_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              dataValid,
  output logic              sleepFlag,
  output logic [DATA_W-1:0] dataOut
);

  localparam int THRESH = ACCESS_CYC + MARGIN_CYC;

  sleepStrobes_t strobes;
  logic addrChange;
  logic reachNext;
  logic countFull;

  addr_idle_sleep_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .THRESH(THRESH)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .addrIn    (addrIn),
    .arrayData (arrayData),
    .strobes   (strobes),
    .addrChange(addrChange),
    .reachNext (reachNext),
    .countFull (countFull),
    .dataOut   (dataOut)
  );

  addr_idle_sleep_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .addrChange(addrChange),
    .reachNext (reachNext),
    .countFull (countFull),
    .dataValid (dataValid),
    .strobes   (strobes),
    .sleepFlag (sleepFlag)
  );

  // R4: output data frozen across any cycle that starts asleep
  p_hold_asleep_r4: assert property (@(posedge clk) disable iff (!rstN)
    sleepFlag |=> $stable(dataOut))
    else $error("output data moved during sleep");

  // R5: output data only moves after a valid pulse
  p_load_needs_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataOut) |-> $past(dataValid))
    else $error("output data moved without a valid pulse");

endmodule

// File: tb/test_addr_idle_sleep.sv
`timescale 1ns/1ps
module test_addr_idle_sleep;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int ACC = 6;
  localparam int MRG = 3;
  localparam int LIM = ACC + MRG;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [DW-1:0] arrayData = '0;
  logic          dataValid = 1'b0;
  logic          expectLoad = 1'b0;
  logic          sleepFlag;
  logic [DW-1:0] dataOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [DW-1:0] expQ[$];
  bit pend = 0;

  always #2.5 clk = ~clk;

  addr_idle_sleep #(.ADDR_W(AW), .DATA_W(DW), .ACCESS_CYC(ACC), .MARGIN_CYC(MRG))
    i_addr_idle_sleep (
      .clk(clk), .rstN(rstN), .addrIn(addrIn), .arrayData(arrayData),
      .dataValid(dataValid), .sleepFlag(sleepFlag), .dataOut(dataOut));

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: a load seen at an edge is compared at the following negedge
  always @(posedge clk) pend <= dataValid && expectLoad;
  always @(negedge clk) begin
    if (pend) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5 queue empty", dataOut, '0);
      end else begin
        logic [DW-1:0] e;
        e = expQ.pop_front();
        check(dataOut == e, "R5 loaded data", dataOut, e);
      end
    end
  end

  // Driver: change address, wait for the array, pulse valid with data
  task automatic doRead(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addrIn = a;
    #1;
    check(sleepFlag == 1'b0, "R3 flag low in change cycle", DW'(sleepFlag), '0);
    @(negedge clk);
    @(negedge clk);
    arrayData = d;
    dataValid = 1'b1;
    expectLoad = 1'b1;
    expQ.push_back(d);
    @(negedge clk);
    dataValid = 1'b0;
    expectLoad = 1'b0;
  endtask

  // After a change at negedge N0, sleep must appear at N(LIM+1)
  task automatic waitSleepFromChange(input int already, input string req);
    for (int k = already; k < LIM; k++) @(negedge clk);
    check(sleepFlag == 1'b0, req, DW'(sleepFlag), '0);
    @(negedge clk);
    check(sleepFlag == 1'b1, req, DW'(sleepFlag), 1);
  endtask

  initial begin
    int n;
    n = 0;
    while (!finished && n < 20000) begin
      @(posedge clk);
      n++;
    end
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=done", n);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sleepFlag == 1'b0, "R6 sleep after reset", DW'(sleepFlag), '0);
    check(dataOut == '0, "R6 data after reset", dataOut, '0);
    rstN = 1'b1;  // release at negedge M0
    for (int k = 1; k < LIM; k++) @(negedge clk);
    check(sleepFlag == 1'b0, "R6 R1 not early after reset", DW'(sleepFlag), '0);
    @(negedge clk);
    check(sleepFlag == 1'b1, "R6 R1 sleep after full count", DW'(sleepFlag), 1);

    // R4: valid pulse while asleep is ignored
    @(negedge clk);
    arrayData = 32'hDEAD_00AB;
    dataValid = 1'b1;
    @(negedge clk);
    dataValid = 1'b0;
    check(dataOut == '0, "R4 valid ignored asleep", dataOut, '0);
    // R2: sleep held while stable
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check(sleepFlag == 1'b1, "R2 sleep held", DW'(sleepFlag), 1);
    end
    check(dataOut == '0, "R4 data held asleep", dataOut, '0);

    // R5 and R1 after a real read
    doRead(16'h0010, 32'h5A5A_1234);
    waitSleepFromChange(3, "R1 sleep after read");
    check(dataOut == 32'h5A5A_1234, "R4 data kept into sleep", dataOut, 32'h5A5A_1234);

    doRead(16'h0011, 32'hC3C3_0F0F);
    doRead(16'hFFFF, 32'hFFFF_FFFF);
    waitSleepFromChange(3, "R1 sleep after last read");

    // R3: mid-count change restarts the count
    @(negedge clk);
    addrIn = 16'h0100;
    #1;
    check(sleepFlag == 1'b0, "R3 wake combinational", DW'(sleepFlag), '0);
    repeat (5) @(negedge clk);
    addrIn = 16'h0101;
    #1;
    check(sleepFlag == 1'b0, "R3 still awake", DW'(sleepFlag), '0);
    waitSleepFromChange(0, "R3 count restarted");
    check(dataOut == 32'hFFFF_FFFF, "R4 data kept after address moves", dataOut, 32'hFFFF_FFFF);
    check(expQ.size() == 0, "R5 all loads seen", DW'(expQ.size()), '0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule